// File: doc/BRIEF.md
# Framed Serial Command Receiver

This block takes write-only 16-bit configuration words from a three-wire link: an active-low frame line, a serial clock and a serial data line. While the frame line is low, the block shifts in data bits on the rising edges of the serial clock, most significant bit first. When the frame line returns high, the block checks the word. A word passes only if exactly sixteen clock edges arrived and its two top bits are zero. A passing word is copied into a held command register, whose fields drive a tone generator: a clock-range code, a frequency code and a level code for each of the two tone groups.

The same frame line also gates the tone. The tone enable stays off while a word is being loaded. It comes on once the frame is high again, provided a good word has been accepted at some point since reset. A failing word leaves the held command unchanged and sets an error flag that stays set until reset. The three link inputs are asynchronous to the system clock. They are resynchronized inside the block, so the system clock must run at least four times faster than the serial clock, and each serial-clock phase must last at least two system clocks.

Top module: `frame_cmd_rx`

## Requirements
- R1: After synchronous reset, every command field output reads 0, `tone_en` is 0 and `bad_frame` is 0.
- R2: An accepted word maps to the outputs as follows: word bits 13:12 drive `clk_code`, bits 11:10 drive `hi_freq`, bits 9:6 drive `hi_lvl`, bits 5:4 drive `lo_freq` and bits 3:0 drive `lo_lvl`. The first bit shifted in is bit 15.
- R3: On the rising edge of `frame_n`, a word is committed to the outputs if exactly 16 serial-clock rising edges occurred while `frame_n` was low and bits 15:14 are 00.
- R4: A frame with fewer than 16 serial-clock rising edges is discarded. The command outputs keep their previous values and `bad_frame` is set.
- R5: A frame with more than 16 serial-clock rising edges is discarded in the same way, with the outputs kept and `bad_frame` set.
- R6: A 16-bit frame whose bits 15:14 are not 00 is discarded, with the outputs kept and `bad_frame` set.
- R7: `bad_frame` stays at 1 until reset, including across later accepted words.
- R8: `tone_en` is 0 while `frame_n` is low, and it goes to 1 within 8 system clocks after `frame_n` rises, once a valid word is held.
- R9: After reset, `tone_en` stays 0 through any number of rejected frames until the first valid word is accepted.
- R10: Serial-clock edges while `frame_n` is high change neither the command outputs nor the bit count of the next frame.
- R11: Each falling edge of `frame_n` restarts the bit count and the shift register, so a word sent after an aborted frame is received intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_n | input | 1 | Frame line: low loads bits, high enables the tone and commits the word on its rising edge |
| ser_clk | input | 1 | Serial clock; data is sampled on its rising edges |
| ser_dat | input | 1 | Serial data, most significant bit first |
| tone_en | output | 1 | Tone generator enable |
| bad_frame | output | 1 | Sticky flag for a rejected frame |
| clk_code | output | 2 | Clock-range code of the held command |
| hi_freq | output | 2 | High-group frequency code |
| hi_lvl | output | 4 | High-group level code |
| lo_freq | output | 2 | Low-group frequency code |
| lo_lvl | output | 4 | Low-group level code |

## Verification
The bench sends frames of 15 and 17 bits. A design that only counted to sixteen, or that let its counter wrap, would accept these and overwrite the held fields. It sends a word with a reserved bit set, which a design without the reserved-bit check would take. It sends a short frame followed by a good one, which exposes a counter that is not cleared at the start of each frame, because that design would reject the good word. It also pulses the serial clock while the frame line is high, and it looks for a tone enable that comes on after rejected frames before any valid word exists, or that stays on during loading.

// File: rtl/cmdrx_pkg.sv
package cmdrx_pkg;

    localparam int unsigned CMD_W = 16;

    // Held command word, most significant field first
    typedef struct packed {
        logic [1:0] rsv;
        logic [1:0] clk_code;
        logic [1:0] hi_freq;
        logic [3:0] hi_lvl;
        logic [1:0] lo_freq;
        logic [3:0] lo_lvl;
    } cmd_t;

    // Reserved bits must be zero for a word to be taken
    function automatic logic rsv_clear(input cmd_t c);
        return (c.rsv == 2'b00);
    endfunction

endpackage

// File: rtl/cmdrx_sync.sv
module cmdrx_sync #(
    parameter int unsigned W      = 3,
    parameter int unsigned STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);
    logic [W-1:0] q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < int'(STAGES); s++) q[s] <= RST_VAL;
        end else begin
            q[0] <= d_in;
            for (int s = 1; s < int'(STAGES); s++) q[s] <= q[s-1];
        end
    end

    assign d_out = q[STAGES-1];
endmodule

// File: rtl/cmdrx_edge.sv
module cmdrx_edge #(
    parameter int unsigned W = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] rise
);
    logic [W-1:0] prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= RST_VAL;
        else     prev <= lvl;
    end

    genvar g;
    generate
        for (g = 0; g < int'(W); g++) begin : g_bit
            assign rise[g] = lvl[g] & ~prev[g];
        end
    endgenerate
endmodule

// File: rtl/cmdrx_shifter.sv
module cmdrx_shifter #(
    parameter int unsigned WORD_W = 16,
    parameter int unsigned CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              shift,
    input  logic              bit_in,
    output logic [WORD_W-1:0] word,
    output logic [CNT_W-1:0]  cnt
);
    // Counter stops one past a full word so that long frames never wrap
    localparam logic [CNT_W-1:0] SAT = CNT_W'(WORD_W + 1);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            word <= '0;
            cnt  <= '0;
        end else if (shift) begin
            word <= {word[WORD_W-2:0], bit_in};
            if (cnt != SAT) cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/cmdrx_commit.sv
module cmdrx_commit
    import cmdrx_pkg::*;
#(
    parameter int unsigned WORD_W = 16,
    parameter int unsigned CNT_W  = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frm_lvl,
    input  logic             frm_rise,
    input  cmd_t             word,
    input  logic [CNT_W-1:0] cnt,
    output cmd_t             cmd_q,
    output logic             err_q,
    output logic             tone_q
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

    logic loaded;
    logic accept;
    logic reject;

    assign accept = frm_rise && (cnt == FULL) && rsv_clear(word);
    assign reject = frm_rise && !accept;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= '0;
            loaded <= 1'b0;
            err_q  <= 1'b0;
            tone_q <= 1'b0;
        end else begin
            if (accept) begin
                cmd_q  <= word;
                loaded <= 1'b1;
            end
            if (reject) err_q <= 1'b1;
            tone_q <= frm_lvl && loaded;
        end
    end
endmodule

// File: rtl/frame_cmd_rx.sv
module frame_cmd_rx
    import cmdrx_pkg::*;
#(
    parameter int unsigned WORD_W      = CMD_W,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       frame_n,
    input  logic       ser_clk,
    input  logic       ser_dat,
    output logic       tone_en,
    output logic       bad_frame,
    output logic [1:0] clk_code,
    output logic [1:0] hi_freq,
    output logic [3:0] hi_lvl,
    output logic [1:0] lo_freq,
    output logic [3:0] lo_lvl
);
    localparam int unsigned CNT_W = $clog2(WORD_W + 2);

    logic [2:0]        sync_out;
    logic              frm_lvl;
    logic              sclk_lvl;
    logic              sdat_lvl;
    logic [2:0]        rises;
    logic              frm_rise;
    logic              frm_fall;
    logic              sclk_rise;
    logic              shift_en;
    logic [WORD_W-1:0] shift_word;
    logic [CNT_W-1:0]  shift_cnt;
    cmd_t              cmd_q;

    // Frame idles high, so its synchronizer resets to 1
    cmdrx_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .d_in  ({frame_n, ser_clk, ser_dat}),
        .d_out (sync_out)
    );

    assign frm_lvl  = sync_out[2];
    assign sclk_lvl = sync_out[1];
    assign sdat_lvl = sync_out[0];

    // Rise detectors on frame, inverted frame (its fall) and serial clock
    cmdrx_edge #(.W(3), .RST_VAL(3'b100)) u_edge (
        .clk  (clk),
        .rst  (rst),
        .lvl  ({frm_lvl, ~frm_lvl, sclk_lvl}),
        .rise (rises)
    );

    assign frm_rise  = rises[2];
    assign frm_fall  = rises[1];
    assign sclk_rise = rises[0];
    assign shift_en  = sclk_rise && !frm_lvl;

    cmdrx_shifter #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_shift (
        .clk    (clk),
        .rst    (rst),
        .clear  (frm_fall),
        .shift  (shift_en),
        .bit_in (sdat_lvl),
        .word   (shift_word),
        .cnt    (shift_cnt)
    );

    cmdrx_commit #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_commit (
        .clk      (clk),
        .rst      (rst),
        .frm_lvl  (frm_lvl),
        .frm_rise (frm_rise),
        .word     (cmd_t'(shift_word)),
        .cnt      (shift_cnt),
        .cmd_q    (cmd_q),
        .err_q    (bad_frame),
        .tone_q   (tone_en)
    );

    assign clk_code = cmd_q.clk_code;
    assign hi_freq  = cmd_q.hi_freq;
    assign hi_lvl   = cmd_q.hi_lvl;
    assign lo_freq  = cmd_q.lo_freq;
    assign lo_lvl   = cmd_q.lo_lvl;
endmodule

// File: rtl/cmdrx_chk.sv
module cmdrx_chk #(
    parameter int unsigned WORD_W = 16,
    parameter int unsigned CNT_W  = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              frm_lvl,
    input logic              frm_rise,
    input logic [CNT_W-1:0]  shift_cnt,
    input logic [WORD_W-1:0] shift_word,
    input logic [WORD_W-1:0] cmd_q,
    input logic              tone_en,
    input logic              bad_frame
);
    // R8: no tone while a word is loading
    a_r8_tone_off_framing: assert property (@(posedge clk) disable iff (rst)
        !frm_lvl |=> !tone_en);

    // R4: the held command only moves on a frame rising edge
    a_r4_hold_without_rise: assert property (@(posedge clk) disable iff (rst)
        !frm_rise |=> $stable(cmd_q));

    // R7: the error flag never clears on its own
    a_r7_err_sticky: assert property (@(posedge clk) disable iff (rst)
        bad_frame |=> bad_frame);

    // R3: a full word with clear reserved bits is taken as shifted
    a_r3_commit_value: assert property (@(posedge clk) disable iff (rst)
        (frm_rise && shift_cnt == CNT_W'(WORD_W) &&
         shift_word[WORD_W-1:WORD_W-2] == 2'b00) |=> cmd_q == $past(shift_word));

    // R5: the bit counter saturates instead of wrapping
    a_r5_cnt_bounded: assert property (@(posedge clk) disable iff (rst)
        shift_cnt <= CNT_W'(WORD_W + 1));

    // R10: the bit count holds while the frame is high
    a_r10_idle_count_frozen: assert property (@(posedge clk) disable iff (rst)
        frm_lvl |=> $stable(shift_cnt));
endmodule

bind frame_cmd_rx cmdrx_chk #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .frm_lvl    (frm_lvl),
    .frm_rise   (frm_rise),
    .shift_cnt  (shift_cnt),
    .shift_word (shift_word),
    .cmd_q      (cmd_q),
    .tone_en    (tone_en),
    .bad_frame  (bad_frame)
);

// File: tb/sim_frame_cmd_rx.sv
module sim_frame_cmd_rx;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       frame_n = 1'b1;
    logic       ser_clk = 1'b0;
    logic       ser_dat = 1'b0;
    logic       tone_en, bad_frame;
    logic [1:0] clk_code, hi_freq, lo_freq;
    logic [3:0] hi_lvl, lo_lvl;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;
    logic [15:0] held = 16'h0000;

    always #4 clk = ~clk;

    frame_cmd_rx u0 (
        .clk(clk), .rst(rst), .frame_n(frame_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .tone_en(tone_en), .bad_frame(bad_frame), .clk_code(clk_code),
        .hi_freq(hi_freq), .hi_lvl(hi_lvl), .lo_freq(lo_freq), .lo_lvl(lo_lvl)
    );

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic fields(input string tag, input logic [15:0] w);
        chk({tag, " clk_code"}, 32'(clk_code), 32'(w[13:12]));
        chk({tag, " hi_freq"},  32'(hi_freq),  32'(w[11:10]));
        chk({tag, " hi_lvl"},   32'(hi_lvl),   32'(w[9:6]));
        chk({tag, " lo_freq"},  32'(lo_freq),  32'(w[5:4]));
        chk({tag, " lo_lvl"},   32'(lo_lvl),   32'(w[3:0]));
    endtask

    task automatic send(input logic [15:0] w, input int nbits);
        frame_n = 1'b0;
        tick(4);
        for (int i = 0; i < nbits; i++) begin
            ser_dat = (i < 16) ? w[15 - (i % 16)] : 1'b0;
            tick(3);
            ser_clk = 1'b1;
            tick(3);
            ser_clk = 1'b0;
        end
        tick(4);
        chk("R8 tone off while loading", 32'(tone_en), 32'd0);
        frame_n = 1'b1;
        tick(8);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        frame_n = 1'b1; ser_clk = 1'b0; ser_dat = 1'b0;
        tick(4);
        rst = 1'b0;
        tick(2);
        held = 16'h0000;
    endtask

    task automatic idle_pulses(input int n);
        ser_dat = 1'b1;
        for (int i = 0; i < n; i++) begin
            tick(3); ser_clk = 1'b1; tick(3); ser_clk = 1'b0;
        end
        tick(4);
    endtask

    task automatic t_reset();
        do_reset();
        fields("R1 reset", 16'h0000);
        chk("R1 reset tone", 32'(tone_en), 32'd0);
        chk("R1 reset err", 32'(bad_frame), 32'd0);
    endtask

    task automatic t_idle_before_load();
        idle_pulses(5);
        fields("R10 idle edges", held);
        chk("R9 no tone before load", 32'(tone_en), 32'd0);
    endtask

    task automatic t_valid(input logic [15:0] w, input string tag);
        send(w, 16);
        held = w;
        fields(tag, held);
        chk({tag, " tone on"}, 32'(tone_en), 32'd1);
    endtask

    task automatic t_short();
        send(16'h0123, 15);
        fields("R4 short frame kept", held);
        chk("R4 short frame err", 32'(bad_frame), 32'd1);
        chk("R8 tone back on", 32'(tone_en), 32'd1);
    endtask

    task automatic t_long();
        send(16'h0555, 17);
        fields("R5 long frame kept", held);
        chk("R5 long frame err", 32'(bad_frame), 32'd1);
    endtask

    task automatic t_reserved();
        send(16'h8001, 16);
        fields("R6 reserved bit kept", held);
        send(16'h4F0F, 16);
        fields("R6 reserved bit14 kept", held);
    endtask

    task automatic t_restart();
        send(16'hFFFF, 5);
        t_valid(16'h0000, "R11 word after abort");
        chk("R7 err still set", 32'(bad_frame), 32'd1);
    endtask

    task automatic t_rejects_after_reset();
        do_reset();
        send(16'h1234, 15);
        chk("R9 tone off after reject", 32'(tone_en), 32'd0);
        send(16'hC000, 16);
        chk("R9 tone off after second reject", 32'(tone_en), 32'd0);
        fields("R9 fields at reset value", 16'h0000);
        t_valid(16'h2AC5, "R9 first valid word");
    endtask

    task automatic t_idle_after_load();
        idle_pulses(7);
        fields("R10 idle edges after load", held);
        t_valid(16'h1E39, "R10 count unaffected");
    endtask

    initial begin
        t_reset();
        t_idle_before_load();
        t_valid(16'h1A7C, "R3 first word");
        chk("R3 err clear", 32'(bad_frame), 32'd0);
        t_valid(16'h3FFF, "R2 all ones");
        t_short();
        t_long();
        t_reserved();
        t_restart();
        t_rejects_after_reset();
        t_idle_after_load();
        summary();
        $finish;
    end
endmodule